// File: doc/BRIEF.md
# Synchronous Serial Master Receiver

This block is the receive side of a serial port that owns the shift clock. It generates a clock on `sclk` from a programmable divider and captures words from a single data line `sdata`. Each word has eight bits, or nine bits when the wide mode is selected. The least significant bit arrives first. The data line is captured at the instant the generated clock falls, so a slave can change its output after each rising edge.

A host drives the block through plain register-style signals. Three configuration bits must all be set before the clock runs. A pulse arms a receive of one word; the armed state clears itself once that word completes. A level enable receives words back to back until it is lowered. A completed word lands in a one-deep holding register together with its ninth bit, and a completion flag is raised. A masked copy of that flag serves as the interrupt, and a read strobe clears the flag. If a word completes while the held word is still unread, an overrun flag is raised. The overrun keeps the held word, stalls the port, and is cleared by lowering the continuous enable.

Top module: `shift_rx_master`

## Requirements
- R1: The shift clock runs only while `portEn`, `syncMode` and `clkMaster` are all 1. If any one of them is 0, `sclk` stays 1 and no word completes, whatever the receive enables are.
- R2: `sclk` is 1 when idle. During a word, each low half and each high half of `sclk` lasts `baudDiv`+1 clock cycles. A word starts with a low half, and its last bit ends with a high half.
- R3: `sdata` is captured at the clock edge on which `sclk` goes from 1 to 0. The first captured bit becomes bit 0 of `rxData`.
- R4: A one-cycle `singleSet` pulse sets `singleEn` to 1. `singleEn` returns to 0 at the edge on which the word completes, and no further word follows.
- R5: While `contEn` is 1, words are received one after another. Each word starts one idle cycle after the previous one completes. Lowering `contEn` in the middle of a word abandons that word: `sclk` returns to 1 and no completion is reported.
- R6: When `contEn` and `singleEn` are both set, continuous reception wins. Reception carries on after `singleEn` has cleared itself.
- R7: With `nineBit` = 1, a word has 9 bits: the first eight go to `rxData` and the ninth to `rxBit9`. With `nineBit` = 0, a word has 8 bits and `rxBit9` is 0.
- R8: `rxDone` becomes 1 in the cycle after a word's final high half. A `rdStrobe` pulse clears it, unless a word completes in the same cycle. `irq` equals `rxDone` AND `irqEn`.
- R9: A word that completes while `rxDone` is 1 and no read is strobed in that cycle sets `overrun`. `rxData` keeps its old value, and no further clock is generated. `overrun` clears on the cycle after `contEn` goes from 1 to 0.
- R10: After reset, `sclk` is 1 and `rxDone`, `overrun`, `singleEn`, `rxBit9` and `rxData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| portEn | input | 1 | Port enable |
| syncMode | input | 1 | Synchronous mode select |
| clkMaster | input | 1 | This side sources the shift clock |
| contEn | input | 1 | Continuous receive enable (level) |
| singleSet | input | 1 | Pulse that arms a receive of one word |
| nineBit | input | 1 | 1 selects 9-bit words |
| baudDiv | input | DIV_W | Half-period of the shift clock minus one, in clock cycles |
| irqEn | input | 1 | Interrupt mask |
| rdStrobe | input | 1 | Read of the data register; clears `rxDone` |
| sdata | input | 1 | Serial data line |
| sclk | output | 1 | Generated shift clock, 1 when idle |
| singleEn | output | 1 | Single-word receive is armed |
| rxData | output | DATA_W | Held received word |
| rxBit9 | output | 1 | Ninth bit of the held word |
| rxDone | output | 1 | A word is held and unread |
| irq | output | 1 | Masked completion interrupt |
| overrun | output | 1 | A word was lost because the held word was unread |

## Verification
The bench builds the block with `DIV_W` = 4 and `DATA_W` = 8. This lets it sweep the divider over 0, 1, 2 and 3 and check the clock half-periods and full 8-bit and 9-bit words in a few hundred cycles each. A behavioural model tracks the cycle position within each word and the bits sampled so far. The model and the block are compared on every clock, so the following are all checked against the cycle-exact timing:
- the idle cycle between continuous words
- abandoning a word when `contEn` drops
- completion coinciding with a read
- overrun

// File: rtl/shift_rx_pkg.sv
package shift_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } rxState_e;

  typedef struct packed {
    logic sample;    // shift sdata into the shift register this edge
    logic commit;    // word finished: move it to the holding register
    logic clrErr;    // continuous enable has just fallen
    logic nineMode;  // word width select for the commit
  } rxStrobe_t;

endpackage

// File: rtl/shift_rx_ctrl.sv
module shift_rx_ctrl
  import shift_rx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterOk,
  input  logic             contEn,
  input  logic             singleSet,
  input  logic             nineBit,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             bufOvr,
  output logic             singleEn,
  output logic             sclk,
  output rxStrobe_t        strobe
);

  localparam int SH_W  = DATA_W + 1;
  localparam int IDX_W = $clog2(SH_W);
  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(SH_W - 1);
  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(DATA_W - 1);

  rxState_e         stateQ;
  logic [DIV_W-1:0] cntQ;
  logic [IDX_W-1:0] bitQ;
  logic             singleQ;
  logic             contPrevQ;

  logic go;
  logic cntZero;
  logic lastBit;
  logic startWord;
  logic nextBit;
  logic wordEnd;

  // Continuous enable or an armed single receive; overrun stalls everything.
  assign go        = masterOk && (contEn || singleQ) && !bufOvr;
  assign cntZero   = (cntQ == '0);
  assign lastBit   = (bitQ == (nineBit ? LAST_WIDE : LAST_NARROW));
  assign startWord = (stateQ == ST_IDLE) && go;
  assign nextBit   = (stateQ == ST_HIGH) && go && cntZero && !lastBit;
  assign wordEnd   = (stateQ == ST_HIGH) && go && cntZero && lastBit;

  assign strobe.sample   = startWord || nextBit;
  assign strobe.commit   = wordEnd;
  assign strobe.clrErr   = contPrevQ && !contEn;
  assign strobe.nineMode = nineBit;

  assign sclk     = (stateQ != ST_LOW);
  assign singleEn = singleQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      bitQ   <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (go) begin
            stateQ <= ST_LOW;
            cntQ   <= baudDiv;
            bitQ   <= '0;
          end
        end
        ST_LOW: begin
          if (!go) begin
            stateQ <= ST_IDLE;
          end else if (cntZero) begin
            stateQ <= ST_HIGH;
            cntQ   <= baudDiv;
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        ST_HIGH: begin
          if (!go) begin
            stateQ <= ST_IDLE;
          end else if (cntZero) begin
            if (lastBit) begin
              stateQ <= ST_IDLE;
            end else begin
              stateQ <= ST_LOW;
              cntQ   <= baudDiv;
              bitQ   <= bitQ + 1'b1;
            end
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      singleQ   <= 1'b0;
      contPrevQ <= 1'b0;
    end else begin
      contPrevQ <= contEn;
      if (!masterOk)      singleQ <= 1'b0;
      else if (singleSet) singleQ <= 1'b1;
      else if (wordEnd)   singleQ <= 1'b0;
    end
  end

  AST_FALL_NEEDS_GO: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> $past(go)); // R1

  AST_LOW_HALF_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LOW && !cntZero && go) |=> !sclk); // R2

  AST_SINGLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wordEnd && !singleSet) |=> !singleEn); // R4

  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE && !go) |=> sclk); // R5

endmodule

// File: rtl/shift_rx_dp.sv
module shift_rx_dp
  import shift_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdata,
  input  logic              rdStrobe,
  input  rxStrobe_t         strobe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxDone,
  output logic              overrun
);

  localparam int SH_W = DATA_W + 1;

  logic [SH_W-1:0]   shQ;
  logic [DATA_W-1:0] dataQ;
  logic              bit9Q;
  logic              doneQ;
  logic              ovrQ;
  logic              accept;

  // The holding register is free if unread data is being read this cycle.
  assign accept = !doneQ || rdStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shQ <= '0;
    end else if (strobe.sample) begin
      shQ <= {sdata, shQ[SH_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      bit9Q <= 1'b0;
      doneQ <= 1'b0;
    end else if (strobe.commit && accept) begin
      dataQ <= strobe.nineMode ? shQ[DATA_W-1:0] : shQ[SH_W-1:1];
      bit9Q <= strobe.nineMode & shQ[SH_W-1];
      doneQ <= 1'b1;
    end else if (rdStrobe) begin
      doneQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovrQ <= 1'b0;
    end else if (strobe.commit && !accept) begin
      ovrQ <= 1'b1;
    end else if (strobe.clrErr) begin
      ovrQ <= 1'b0;
    end
  end

  assign rxData  = dataQ;
  assign rxBit9  = bit9Q;
  assign rxDone  = doneQ;
  assign overrun = ovrQ;

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !strobe.commit) |=> !rxDone); // R8

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && doneQ && !rdStrobe) |=> (overrun && $stable(rxData))); // R9

  AST_NO_SAMPLE_IN_OVR: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> !strobe.sample); // R9

  AST_NARROW_NINTH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && accept && !strobe.nineMode) |=> !rxBit9); // R7

endmodule

// File: rtl/shift_rx_master.sv
module shift_rx_master
  import shift_rx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              syncMode,
  input  logic              clkMaster,
  input  logic              contEn,
  input  logic              singleSet,
  input  logic              nineBit,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic              irqEn,
  input  logic              rdStrobe,
  input  logic              sdata,
  output logic              sclk,
  output logic              singleEn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxDone,
  output logic              irq,
  output logic              overrun
);

  rxStrobe_t strobe;
  logic      masterOk;

  assign masterOk = portEn && syncMode && clkMaster;

  shift_rx_ctrl #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .masterOk  (masterOk),
    .contEn    (contEn),
    .singleSet (singleSet),
    .nineBit   (nineBit),
    .baudDiv   (baudDiv),
    .bufOvr    (overrun),
    .singleEn  (singleEn),
    .sclk      (sclk),
    .strobe    (strobe)
  );

  shift_rx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sdata    (sdata),
    .rdStrobe (rdStrobe),
    .strobe   (strobe),
    .rxData   (rxData),
    .rxBit9   (rxBit9),
    .rxDone   (rxDone),
    .overrun  (overrun)
  );

  assign irq = rxDone && irqEn;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rxDone && irqEn)); // R8

endmodule

// File: tb/shift_rx_master_bench.sv
`timescale 1ns/1ps
module shift_rx_master_bench;

  localparam int DIV_W  = 4;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rstN = 1'b0;
  logic             portEn = 1'b0, syncMode = 1'b0, clkMaster = 1'b0;
  logic             contEn = 1'b0, singleSet = 1'b0, nineBit = 1'b0;
  logic [DIV_W-1:0] baudDiv = '0;
  logic             irqEn = 1'b0, rdStrobe = 1'b0, sdata = 1'b0;
  logic             sclk, singleEn, rxBit9, rxDone, irq, overrun;
  logic [DATA_W-1:0] rxData;

  shift_rx_master #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_shift_rx_master (
    .clk(clk), .rstN(rstN), .portEn(portEn), .syncMode(syncMode),
    .clkMaster(clkMaster), .contEn(contEn), .singleSet(singleSet),
    .nineBit(nineBit), .baudDiv(baudDiv), .irqEn(irqEn),
    .rdStrobe(rdStrobe), .sdata(sdata), .sclk(sclk), .singleEn(singleEn),
    .rxData(rxData), .rxBit9(rxBit9), .rxDone(rxDone), .irq(irq),
    .overrun(overrun)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [8:0] curPat = '0;
  bit   mBusy = 0, mSingle = 0, mDone = 0, mOvr = 0, mB9 = 0, mContPrev = 0;
  int   mT = 0, mBitCnt = 0;
  logic [7:0] mData = '0;
  logic mBits [9];
  int   h, nb;
  bit   mOk, mGo, mCommit, mAccept;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mSingle = 0; mDone = 0; mOvr = 0; mB9 = 0; mContPrev = 0;
      mT = 0; mBitCnt = 0; mData = '0;
    end else begin
      h       = int'(baudDiv) + 1;
      nb      = nineBit ? 9 : 8;
      mOk     = portEn && syncMode && clkMaster;
      mGo     = mOk && (contEn || mSingle) && !mOvr;
      mAccept = !mDone || rdStrobe;
      mCommit = 0;
      if (!mBusy) begin
        if (mGo) begin
          mBusy = 1; mT = 0; mBits[0] = sdata; mBitCnt = 1;
        end
      end else if (!mGo) begin
        mBusy = 0; mBitCnt = 0;
      end else if (mT == nb * 2 * h - 1) begin
        mCommit = 1; mBusy = 0;
      end else begin
        mT++;
        if (mT % (2 * h) == 0) begin
          mBits[mBitCnt] = sdata;
          mBitCnt++;
        end
      end
      if (mCommit && mAccept) begin
        for (int i = 0; i < 8; i++) mData[i] = mBits[i];
        mB9   = (nb == 9) ? mBits[8] : 1'b0;
        mDone = 1;
      end else if (rdStrobe) begin
        mDone = 0;
      end
      if (mCommit && !mAccept) mOvr = 1;
      else if (mContPrev && !contEn) mOvr = 0;
      if (mCommit) mBitCnt = 0;
      if (!mOk) mSingle = 0;
      else if (singleSet) mSingle = 1;
      else if (mCommit) mSingle = 0;
      mContPrev = contEn;
    end
  end

  // Slave drives the next bit after each edge, away from the sampling edge
  always @(negedge clk) sdata <= (mBitCnt < 9) ? curPat[mBitCnt] : 1'b0;

  // Compare every cycle
  always @(negedge clk) begin
    if (rstN) begin
      automatic int hh = int'(baudDiv) + 1;
      automatic bit expSclk = !(mBusy && ((mT % (2 * hh)) < hh));
      chk(sclk === expSclk, "R2 sclk", sclk, expSclk);
      chk(rxData === mData, "R3 rxData", rxData, mData);
      chk(rxBit9 === mB9, "R7 rxBit9", rxBit9, mB9);
      chk(rxDone === mDone, "R8 rxDone", rxDone, mDone);
      chk(irq === (mDone && irqEn), "R8 irq", irq, mDone && irqEn);
      chk(overrun === mOvr, "R9 overrun", overrun, mOvr);
      chk(singleEn === mSingle, "R4 singleEn", singleEn, mSingle);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pat(input logic [8:0] v);
    @(posedge clk); #1; curPat = v;
    @(negedge clk);
  endtask

  task automatic pulse_single();
    singleSet = 1'b1; @(negedge clk); singleSet = 1'b0;
  endtask

  task automatic pulse_read();
    rdStrobe = 1'b1; @(negedge clk); rdStrobe = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!rxDone && n < 2000) begin @(negedge clk); n++; end
    chk(rxDone === 1'b1, req, rxDone, 1);
  endtask

  task automatic count_lows(input int n, output int lows);
    lows = 0;
    repeat (n) begin @(negedge clk); if (!sclk) lows++; end
  endtask

  initial begin
    int lows, lo, hi, n;
    tick(4);
    // R10 reset state
    chk(sclk === 1'b1, "R10 sclk", sclk, 1);
    chk(rxDone === 1'b0 && overrun === 1'b0, "R10 flags", {rxDone, overrun}, 0);
    chk(singleEn === 1'b0 && rxBit9 === 1'b0, "R10 single/bit9", {singleEn, rxBit9}, 0);
    chk(rxData === '0, "R10 rxData", rxData, 0);
    rstN = 1'b1;
    tick(2);

    // R1: master mode needs all three bits
    portEn = 1; syncMode = 1; clkMaster = 0; contEn = 1; baudDiv = 1;
    count_lows(40, lows);
    chk(lows == 0 && !rxDone, "R1 clkMaster low", lows, 0);
    clkMaster = 1; portEn = 0;
    count_lows(40, lows);
    chk(lows == 0 && !rxDone, "R1 portEn low", lows, 0);
    portEn = 1; syncMode = 0;
    count_lows(40, lows);
    chk(lows == 0 && !rxDone, "R1 syncMode low", lows, 0);
    contEn = 0; tick(1); syncMode = 1; tick(2);

    // R3 / R4: single 8-bit word
    set_pat(9'h0A5);
    pulse_single();
    chk(singleEn === 1'b1, "R4 armed", singleEn, 1);
    wait_done("R4 single done");
    chk(rxData === 8'hA5, "R3 lsb first", rxData, 8'hA5);
    chk(rxBit9 === 1'b0, "R7 narrow bit9", rxBit9, 0);
    chk(singleEn === 1'b0, "R4 self clear", singleEn, 0);
    count_lows(30, lows);
    chk(lows == 0, "R4 one word only", lows, 0);
    irqEn = 0; tick(1);
    chk(irq === 1'b0, "R8 irq masked", irq, 0);
    irqEn = 1; tick(1);
    chk(irq === 1'b1, "R8 irq", irq, 1);
    pulse_read();
    chk(rxDone === 1'b0 && irq === 1'b0, "R8 read clears", rxDone, 0);

    // R2: half periods with divider 3
    baudDiv = 3;
    set_pat(9'h03C);
    pulse_single();
    while (sclk) @(negedge clk);
    lo = 0; while (!sclk) begin lo++; @(negedge clk); end
    hi = 0; while (sclk && hi < 50) begin hi++; @(negedge clk); end
    chk(lo == 4, "R2 low half", lo, 4);
    chk(hi == 4, "R2 high half", hi, 4);
    wait_done("R2 done");
    chk(rxData === 8'h3C, "R3 data", rxData, 8'h3C);
    pulse_read();

    // R7: nine-bit words, divider 0
    nineBit = 1; baudDiv = 0;
    set_pat(9'h1C3);
    pulse_single();
    wait_done("R7 done");
    chk(rxData === 8'hC3 && rxBit9 === 1'b1, "R7 nine set", {rxBit9, rxData}, 9'h1C3);
    pulse_read();
    set_pat(9'h07E);
    pulse_single();
    wait_done("R7 done2");
    chk(rxData === 8'h7E && rxBit9 === 1'b0, "R7 nine clear", {rxBit9, rxData}, 9'h07E);
    pulse_read();
    nineBit = 0;

    // R5: continuous, then abandon mid-word
    baudDiv = 2;
    set_pat(9'h05A);
    contEn = 1;
    for (int w = 0; w < 3; w++) begin
      wait_done("R5 cont done");
      chk(rxData === 8'h5A, "R5 cont data", rxData, 8'h5A);
      pulse_read();
    end
    while (sclk) @(negedge clk);
    tick(3);
    contEn = 0;
    tick(3);
    chk(sclk === 1'b1, "R5 abort idle", sclk, 1);
    tick(60);
    chk(rxDone === 1'b0, "R5 abort no done", rxDone, 0);

    // R6: both enables, continuous wins
    set_pat(9'h096);
    contEn = 1;
    pulse_single();
    wait_done("R6 first");
    chk(singleEn === 1'b0, "R6 single cleared", singleEn, 0);
    chk(rxData === 8'h96, "R6 data", rxData, 8'h96);
    pulse_read();
    wait_done("R6 second word");
    pulse_read();
    contEn = 0;
    tick(5);

    // R9: overrun
    set_pat(9'h011);
    contEn = 1;
    wait_done("R9 first");
    set_pat(9'h022);
    n = 0;
    while (!overrun && n < 500) begin @(negedge clk); n++; end
    chk(overrun === 1'b1, "R9 set", overrun, 1);
    chk(rxData === 8'h11, "R9 data kept", rxData, 8'h11);
    count_lows(60, lows);
    chk(lows == 0, "R9 blocked", lows, 0);
    contEn = 0;
    tick(1);
    chk(overrun === 1'b0, "R9 cleared", overrun, 0);
    chk(rxDone === 1'b1, "R9 held word", rxDone, 1);
    pulse_read();
    tick(5);
    finish_run();
  end

endmodule